// File: doc/BRIEF.md
# Double-Buffered Configuration Commit and Event Interrupt Controller

This block keeps a bank of configuration words in two copies. Software writes only the staging copy, which it can read back at any time. The display datapath sees only the live copy. Software moves the whole staging bank into the live bank by posting a commit request. The request either takes effect on the next clock or waits for the next vertical blanking event. A request bit reads back as set while it waits and clears itself once the copy has been made.

The same block gathers four event sources into a sticky status word:
- a scan-line event
- a pixel FIFO underrun
- a bus transfer error
- a commit-done event, which the block raises itself.

An enable word masks the status word, and the masked result is OR-reduced onto one interrupt line. Software acknowledges events through a separate write-one-to-clear word. The usual handler reads the status word and writes that same value back to the acknowledge word.

Register map (word addresses):

| Address | Content |
|---|---|
| 0 | commit control |
| 1 | interrupt enable |
| 2 | interrupt status, read-only |
| 3 | acknowledge, write-only, reads as zero |
| 4 to 4+NUM_CFG-1 | staging configuration words |

Any other address reads as zero. When software shuts the display down, it should post an immediate commit so that the cleared configuration is live before the controller stops.

Top module: `cfg_commit_irq_ctrl`

## Requirements
- R1: After reset, every live word, every staging word, the commit control word, the enable word and the status word are all zero, and irq_o is low.
- R2: A write to address 4+i changes staging word i, and that word reads back at once. The live bank does not change on any cycle in which no commit is carried out.
- R3: Writing a 1 to bit 0 of the commit word (address 0) makes bit 0 read as 1 for one cycle. On the next clock edge every staging word is copied to the live bank and bit 0 clears.
- R4: Writing a 1 to bit 1 of the commit word leaves bit 1 set until a clock edge at which vblank_i is high while the bit was already set. At that edge the copy is made and the bit clears. A request written in the same cycle as a vblank pulse waits for the next pulse.
- R5: An immediate commit also carries out and clears a pending vblank request. Writing 0 to a commit bit cancels nothing.
- R6: A commit copies the staging values held before its edge. A staging write at the commit edge reaches only the staging copy.
- R7: Status bits are bit 0 line event, bit 1 FIFO underrun, bit 2 transfer error and bit 3 commit done. Each is set by a one-cycle high on its source. Bit 3 is set at the same edge at which the live bank is updated. Writes to address 2 have no effect.
- R8: Writing a word to address 3 clears each status bit whose position holds a 1 and leaves every other bit alone. If a source event and a clear hit the same bit in one cycle, the bit ends up set.
- R9: irq_o is high exactly when some status bit and the enable bit at the same position (address 1, bits 0 to 3) are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_waddr_i | input | ADDR_W | Write word address |
| reg_wdata_i | input | DATA_W | Write data |
| reg_raddr_i | input | ADDR_W | Read word address |
| reg_rdata_o | output | DATA_W | Read data, combinational from the address |
| vblank_i | input | 1 | Vertical blanking event, one cycle high |
| line_evt_i | input | 1 | Scan-line event pulse |
| underrun_evt_i | input | 1 | FIFO underrun pulse |
| xfer_err_evt_i | input | 1 | Transfer error pulse |
| active_cfg_o | output | NUM_CFG*DATA_W | Live configuration bank, word i at bits i*DATA_W and up |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The bench builds the block with DATA_W=8, NUM_CFG=3 and ADDR_W=3. This gives a 3-bit address space in which address 7 is the only unmapped word. With only four sources, two exhaustive sweeps become cheap. The first covers all 16 acknowledge masks against a full status word. The second covers all 256 pairings of status and enable against the expected OR-reduction. The small bank also makes it quick to compare every live word after each commit ordering: immediate, deferred, a request that coincides with a vblank pulse, a deferred request overtaken by an immediate one, and a staging write on the commit edge.

// File: rtl/cfg_commit_pkg.sv
package cfg_commit_pkg;
  localparam int NUM_SRC      = 4;
  localparam int REG_COMMIT   = 0;
  localparam int REG_IRQ_EN   = 1;
  localparam int REG_IRQ_STAT = 2;
  localparam int REG_IRQ_ACK  = 3;
  localparam int REG_CFG_BASE = 4;

  localparam int SRC_LINE     = 0;
  localparam int SRC_UNDERRUN = 1;
  localparam int SRC_XFER_ERR = 2;
  localparam int SRC_COMMIT   = 3;

  localparam int CMT_NOW_BIT  = 0;
  localparam int CMT_VBL_BIT  = 1;

  typedef logic [NUM_SRC-1:0] src_vec_t;

  // Sticky flag update: clear first, then set, so a set event wins.
  function automatic src_vec_t flag_update(src_vec_t cur, src_vec_t set_v, src_vec_t ack_v);
    flag_update = (cur & ~ack_v) | set_v;
  endfunction

  function automatic logic irq_reduce(src_vec_t st, src_vec_t en);
    irq_reduce = |(st & en);
  endfunction

  // Pending-bit update for one commit request kind.
  function automatic logic pend_update(logic cur, logic req, logic fired);
    pend_update = req | (cur & ~fired);
  endfunction
endpackage

// File: rtl/commit_sequencer.sv
module commit_sequencer
  import cfg_commit_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_now_i,
  input  logic req_vbl_i,
  input  logic vblank_i,
  output logic now_pend_o,
  output logic vbl_pend_o,
  output logic fire_o
);
  logic now_q, vbl_q;
  logic fire_now, fire_vbl;

  assign fire_now = now_q;
  assign fire_vbl = vbl_q & vblank_i;
  assign fire_o   = fire_now | fire_vbl;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      now_q <= 1'b0;
      vbl_q <= 1'b0;
    end else begin
      now_q <= pend_update(now_q, req_now_i, fire_o);
      vbl_q <= pend_update(vbl_q, req_vbl_i, fire_o);
    end
  end

  assign now_pend_o = now_q;
  assign vbl_pend_o = vbl_q;
endmodule

// File: rtl/cfg_dual_bank.sv
module cfg_dual_bank #(
  parameter int DATA_W  = 32,
  parameter int NUM_CFG = 8,
  parameter int ADDR_W  = 4
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      wr_i,
  input  logic [ADDR_W-1:0]         waddr_i,
  input  logic [DATA_W-1:0]         wdata_i,
  input  logic                      commit_i,
  output logic [NUM_CFG*DATA_W-1:0] staging_o,
  output logic [NUM_CFG*DATA_W-1:0] live_o
);
  import cfg_commit_pkg::*;

  for (genvar i = 0; i < NUM_CFG; i++) begin : g_word
    localparam logic [ADDR_W-1:0] WORD_ADDR = ADDR_W'(REG_CFG_BASE + i);
    logic [DATA_W-1:0] stage_q, live_q;
    logic              hit;

    assign hit = wr_i && (waddr_i == WORD_ADDR);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        stage_q <= '0;
        live_q  <= '0;
      end else begin
        if (hit)      stage_q <= wdata_i;
        if (commit_i) live_q  <= stage_q;
      end
    end

    assign staging_o[i*DATA_W +: DATA_W] = stage_q;
    assign live_o[i*DATA_W +: DATA_W]    = live_q;
  end
endmodule

// File: rtl/event_status_unit.sv
module event_status_unit
  import cfg_commit_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  src_vec_t set_i,
  input  logic     ack_wr_i,
  input  src_vec_t ack_mask_i,
  input  logic     en_wr_i,
  input  src_vec_t en_data_i,
  output src_vec_t status_o,
  output src_vec_t enable_o,
  output logic     irq_o
);
  src_vec_t stat_q, en_q, ack_eff;

  assign ack_eff = ack_wr_i ? ack_mask_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q <= '0;
      en_q   <= '0;
    end else begin
      stat_q <= flag_update(stat_q, set_i, ack_eff);
      if (en_wr_i) en_q <= en_data_i;
    end
  end

  assign status_o = stat_q;
  assign enable_o = en_q;
  assign irq_o    = irq_reduce(stat_q, en_q);
endmodule

// File: rtl/cfg_commit_irq_ctrl.sv
module cfg_commit_irq_ctrl
  import cfg_commit_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int NUM_CFG = 8,
  parameter int ADDR_W  = 4
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      reg_wr_i,
  input  logic [ADDR_W-1:0]         reg_waddr_i,
  input  logic [DATA_W-1:0]         reg_wdata_i,
  input  logic [ADDR_W-1:0]         reg_raddr_i,
  output logic [DATA_W-1:0]         reg_rdata_o,
  input  logic                      vblank_i,
  input  logic                      line_evt_i,
  input  logic                      underrun_evt_i,
  input  logic                      xfer_err_evt_i,
  output logic [NUM_CFG*DATA_W-1:0] active_cfg_o,
  output logic                      irq_o
);
  localparam int BANK_W = NUM_CFG * DATA_W;
  localparam logic [ADDR_W-1:0] A_COMMIT = ADDR_W'(REG_COMMIT);
  localparam logic [ADDR_W-1:0] A_EN     = ADDR_W'(REG_IRQ_EN);
  localparam logic [ADDR_W-1:0] A_STAT   = ADDR_W'(REG_IRQ_STAT);
  localparam logic [ADDR_W-1:0] A_ACK    = ADDR_W'(REG_IRQ_ACK);

  // Named internal events, used by the bound checker.
  logic        commit_wr, ack_wr, en_wr;
  logic        now_pend, vbl_pend, commit_fire;
  src_vec_t    evt_set, irq_stat, irq_en;
  logic [BANK_W-1:0] staging_flat;

  assign commit_wr = reg_wr_i && (reg_waddr_i == A_COMMIT);
  assign ack_wr    = reg_wr_i && (reg_waddr_i == A_ACK);
  assign en_wr     = reg_wr_i && (reg_waddr_i == A_EN);

  commit_sequencer u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_now_i  (commit_wr && reg_wdata_i[CMT_NOW_BIT]),
    .req_vbl_i  (commit_wr && reg_wdata_i[CMT_VBL_BIT]),
    .vblank_i   (vblank_i),
    .now_pend_o (now_pend),
    .vbl_pend_o (vbl_pend),
    .fire_o     (commit_fire)
  );

  cfg_dual_bank #(.DATA_W(DATA_W), .NUM_CFG(NUM_CFG), .ADDR_W(ADDR_W)) u_bank (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (reg_wr_i),
    .waddr_i   (reg_waddr_i),
    .wdata_i   (reg_wdata_i),
    .commit_i  (commit_fire),
    .staging_o (staging_flat),
    .live_o    (active_cfg_o)
  );

  always_comb begin
    evt_set               = '0;
    evt_set[SRC_LINE]     = line_evt_i;
    evt_set[SRC_UNDERRUN] = underrun_evt_i;
    evt_set[SRC_XFER_ERR] = xfer_err_evt_i;
    evt_set[SRC_COMMIT]   = commit_fire;
  end

  event_status_unit u_evt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .set_i      (evt_set),
    .ack_wr_i   (ack_wr),
    .ack_mask_i (reg_wdata_i[NUM_SRC-1:0]),
    .en_wr_i    (en_wr),
    .en_data_i  (reg_wdata_i[NUM_SRC-1:0]),
    .status_o   (irq_stat),
    .enable_o   (irq_en),
    .irq_o      (irq_o)
  );

  always_comb begin
    reg_rdata_o = '0;
    case (reg_raddr_i)
      A_COMMIT: reg_rdata_o = {{(DATA_W-2){1'b0}}, vbl_pend, now_pend};
      A_EN:     reg_rdata_o = {{(DATA_W-NUM_SRC){1'b0}}, irq_en};
      A_STAT:   reg_rdata_o = {{(DATA_W-NUM_SRC){1'b0}}, irq_stat};
      default: begin
        for (int i = 0; i < NUM_CFG; i++) begin
          if (reg_raddr_i == ADDR_W'(REG_CFG_BASE + i))
            reg_rdata_o = staging_flat[i*DATA_W +: DATA_W];
        end
      end
    endcase
  end
endmodule

// File: rtl/cfg_commit_irq_chk.sv
module cfg_commit_irq_chk #(
  parameter int DATA_W  = 32,
  parameter int NUM_CFG = 8
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic                      commit_fire,
  input logic                      now_pend,
  input logic                      vbl_pend,
  input logic                      commit_wr,
  input logic                      vblank_i,
  input logic                      underrun_evt_i,
  input logic [3:0]                irq_stat,
  input logic [3:0]                irq_en,
  input logic                      irq_o,
  input logic [NUM_CFG*DATA_W-1:0] active_cfg_o,
  input logic [NUM_CFG*DATA_W-1:0] staging_flat
);
  assert_live_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !commit_fire |=> $stable(active_cfg_o));

  assert_now_selfclear_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    now_pend && !commit_wr |=> !now_pend);

  assert_vbl_waits_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vbl_pend && !vblank_i && !now_pend |=> vbl_pend);

  assert_now_takes_vbl_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    now_pend && !commit_wr |=> !vbl_pend);

  assert_copy_snapshot_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_fire |=> active_cfg_o == $past(staging_flat));

  assert_done_flag_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_fire |=> irq_stat[3]);

  assert_set_wins_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    underrun_evt_i |=> irq_stat[1]);

  assert_masked_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_en == 4'd0 |-> !irq_o);
endmodule

bind cfg_commit_irq_ctrl cfg_commit_irq_chk #(.DATA_W(DATA_W), .NUM_CFG(NUM_CFG)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .commit_fire    (commit_fire),
  .now_pend       (now_pend),
  .vbl_pend       (vbl_pend),
  .commit_wr      (commit_wr),
  .vblank_i       (vblank_i),
  .underrun_evt_i (underrun_evt_i),
  .irq_stat       (irq_stat),
  .irq_en         (irq_en),
  .irq_o          (irq_o),
  .active_cfg_o   (active_cfg_o),
  .staging_flat   (staging_flat)
);

// File: tb/cfg_commit_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module cfg_commit_irq_ctrl_tb_top;
  localparam int DW = 8;
  localparam int NC = 3;
  localparam int AW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [AW-1:0] waddr = '0, raddr = '0;
  logic [DW-1:0] wdata = '0, rdata;
  logic vblank = 1'b0, line_e = 1'b0, under_e = 1'b0, xerr_e = 1'b0;
  logic [NC*DW-1:0] active;
  logic irq;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  cfg_commit_irq_ctrl #(.DATA_W(DW), .NUM_CFG(NC), .ADDR_W(AW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(wr_en), .reg_waddr_i(waddr),
    .reg_wdata_i(wdata), .reg_raddr_i(raddr), .reg_rdata_o(rdata),
    .vblank_i(vblank), .line_evt_i(line_e), .underrun_evt_i(under_e),
    .xfer_err_evt_i(xerr_e), .active_cfg_o(active), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%0h expected=%0h", req, got, exp);
    end
  endtask

  task automatic rd(input int a, output logic [DW-1:0] v);
    raddr = AW'(a);
    #1;
    v = rdata;
  endtask

  task automatic wr(input int a, input logic [DW-1:0] d);
    wr_en = 1'b1; waddr = AW'(a); wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse(input logic l, input logic u, input logic x, input logic vb);
    line_e = l; under_e = u; xerr_e = x; vblank = vb;
    @(negedge clk);
    line_e = 1'b0; under_e = 1'b0; xerr_e = 1'b0; vblank = 1'b0;
  endtask

  function automatic logic [DW-1:0] live(input int i);
    return active[i*DW +: DW];
  endfunction

  task automatic chk_live(input string req, input logic [DW-1:0] e0,
                          input logic [DW-1:0] e1, input logic [DW-1:0] e2);
    chk(req, live(0), e0);
    chk(req, live(1), e1);
    chk(req, live(2), e2);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    for (int a = 0; a < 8; a++) begin
      rd(a, v);
      chk("R1 reg", v, '0);
    end
    chk_live("R1 live", 0, 0, 0);
    chk("R1 irq", irq, 1'b0);

    // R2: staging writes do not reach live bank
    wr(4, 8'h11); wr(5, 8'h22); wr(6, 8'h33);
    rd(4, v); chk("R2 rb0", v, 8'h11);
    rd(5, v); chk("R2 rb1", v, 8'h22);
    rd(6, v); chk("R2 rb2", v, 8'h33);
    rd(7, v); chk("R2 unmapped", v, 8'h00);
    repeat (3) @(negedge clk);
    chk_live("R2 live held", 0, 0, 0);

    // R3: immediate commit, R7 done flag
    wr(0, 8'h01);
    rd(0, v); chk("R3 pending", v, 8'h01);
    chk_live("R3 before", 0, 0, 0);
    @(negedge clk);
    chk_live("R3 after", 8'h11, 8'h22, 8'h33);
    rd(0, v); chk("R3 selfclear", v, 8'h00);
    rd(2, v); chk("R7 done flag", v, 8'h08);
    wr(3, 8'h0F);
    rd(2, v); chk("R8 ack all", v, 8'h00);

    // R4: deferred commit waits for vblank
    wr(4, 8'h44); wr(5, 8'h55); wr(6, 8'h66);
    wr(0, 8'h02);
    repeat (3) @(negedge clk);
    rd(0, v); chk("R4 pending", v, 8'h02);
    chk_live("R4 waiting", 8'h11, 8'h22, 8'h33);
    rd(2, v); chk("R4 no done yet", v, 8'h00);
    pulse(0, 0, 0, 1);
    chk_live("R4 at vblank", 8'h44, 8'h55, 8'h66);
    rd(0, v); chk("R4 selfclear", v, 8'h00);
    rd(2, v); chk("R7 done at vblank", v, 8'h08);
    wr(3, 8'h08);

    // R4: request coinciding with vblank waits for next one
    wr(4, 8'h77);
    wr_en = 1'b1; waddr = 3'd0; wdata = 8'h02; vblank = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; vblank = 1'b0;
    rd(0, v); chk("R4 coincident pending", v, 8'h02);
    chk("R4 coincident no copy", live(0), 8'h44);
    pulse(0, 0, 0, 1);
    chk("R4 next vblank", live(0), 8'h77);

    // R5: zero write cancels nothing, immediate overtakes deferred
    wr(5, 8'h88);
    wr(0, 8'h02);
    wr(0, 8'h00);
    rd(0, v); chk("R5 zero no cancel", v, 8'h02);
    wr(0, 8'h01);
    rd(0, v); chk("R5 both pending", v, 8'h03);
    @(negedge clk);
    rd(0, v); chk("R5 both cleared", v, 8'h00);
    chk("R5 copied", live(1), 8'h88);
    pulse(0, 0, 0, 1);
    chk("R5 no second copy", live(1), 8'h88);

    // R6: staging write on the commit edge
    wr(4, 8'hA1);
    wr(0, 8'h01);
    wr(4, 8'hB2);
    chk("R6 live gets old", live(0), 8'hA1);
    rd(4, v); chk("R6 staging new", v, 8'hB2);
    @(negedge clk);
    chk("R6 live held", live(0), 8'hA1);

    // R7: source bit positions, status read-only
    wr(3, 8'h0F);
    pulse(1, 0, 0, 0); rd(2, v); chk("R7 line bit0", v, 8'h01);
    pulse(0, 1, 0, 0); rd(2, v); chk("R7 underrun bit1", v, 8'h03);
    pulse(0, 0, 1, 0); rd(2, v); chk("R7 xfer bit2", v, 8'h07);
    wr(2, 8'h00);      rd(2, v); chk("R7 status read-only", v, 8'h07);

    // R8: acknowledge sweep
    for (int c = 0; c < 16; c++) begin
      wr(0, 8'h01);
      pulse(1, 1, 1, 0);
      wr(3, DW'(c));
      rd(2, v); chk("R8 ack mask", v, DW'(4'hF & ~c));
      rd(3, v); chk("R8 ack reads zero", v, 8'h00);
    end
    // R8: set wins over clear
    wr(3, 8'h0F);
    wr_en = 1'b1; waddr = 3'd3; wdata = 8'h02; under_e = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; under_e = 1'b0;
    rd(2, v); chk("R8 set wins", v, 8'h02);

    // R9: status x enable sweep
    for (int s = 0; s < 16; s++) begin
      for (int e = 0; e < 16; e++) begin
        wr(3, 8'h0F);
        if (s[3]) begin
          wr(0, 8'h01);
          @(negedge clk);
        end
        if (s[2:0] != 0) pulse(s[0], s[1], s[2], 0);
        wr(1, DW'(e));
        rd(2, v); chk("R9 status", v, DW'(s));
        rd(1, v); chk("R9 enable rb", v, DW'(e));
        chk("R9 irq", irq, ((s & e) != 0) ? 1'b1 : 1'b0);
      end
    end

    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule